// File: doc/BRIEF.md
# Latched Alarm Status Interrupt Controller

This block collects status conditions from a line framer and reports them to a host through a small synchronous register port. Each of two latched status banks takes one input per bit. A parameter decides, bit by bit, whether that input is a level alarm or a single-cycle event. Alarm inputs pass through a synchronizer first. Event inputs are taken as synchronous to the block clock.

A third register reads back a separate group of condition inputs as they are at the moment of the read. It holds no latched state and needs no write before a read.

Each latched bank has a mask register, and its bits can pull the shared active-low interrupt line. Every status bit has two flags. The status flag records that the condition was seen. The pending flag records that the host has not yet read about it. An alarm bit raises its pending flag when the alarm comes on and again when it goes off. An event bit raises its pending flag each time the event fires. A host read of a bank drops the pending flags of that bank, which releases the interrupt line. A status bit is cleared only by a write that has a 1 in that bit position.

Top module: `stat_irq_ctrl`

## Requirements
- R1: After synchronous reset, every status flag, pending flag and mask bit is 0, `irq_n` is 1 and `rd_data` is 0.
- R2: An event bit (a bit whose entry in `ALARM_SEL0`/`ALARM_SEL1` is 0) that is high at a clock edge sets both its status flag and its pending flag at that same edge.
- R3: An alarm bit (a bit whose entry in the select parameter is 1) is sampled through `SYNC_DEPTH` flops. Its status flag is set at every edge where the synchronized level is 1. Its pending flag is set at every edge where the synchronized level differs from its value one cycle earlier, so a rising change sets it and a falling change sets it.
- R4: A write to a status address (0 for bank 0, 1 for bank 1) clears each status flag whose `wr_data` bit is 1 and leaves the flags whose bit is 0 unchanged.
- R5: If a status bit is set by its input in the same cycle that a write clears it, the status flag ends at 1. This also means that an alarm bit whose alarm is still present stays set after a clear.
- R6: A read of a status address returns that bank's status flags and clears all of that bank's pending flags. A trigger that arrives in the same cycle as the read leaves its pending flag at 1. The read does not change the status flags or the other bank.
- R7: `irq_n` is 0 exactly when some bit has both its pending flag and its mask bit at 1. A mask bit of 1 enables that bit.
- R8: A read of address 2 returns the value of `live_in` at that clock edge. A write to address 2 has no effect.
- R9: A write to address 4 (bank 0) or address 5 (bank 1) loads that mask register from `wr_data`. A read of the same address returns the mask.
- R10: `rd_data` is loaded at the edge where `rd_en` is high and holds its value in every other cycle. Reads of addresses 3, 6 and 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src0_in | input | REG_W | Alarm/event inputs of bank 0 |
| src1_in | input | REG_W | Alarm/event inputs of bank 1 |
| live_in | input | REG_W | Condition inputs seen by the real-time register |
| addr | input | 3 | Register address |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_en | input | 1 | Write strobe, one cycle per access |
| wr_data | input | REG_W | Write data |
| rd_data | output | REG_W | Registered read data |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The bench builds the block with `REG_W` of 8 and `SYNC_DEPTH` of 2. It sets `ALARM_SEL0` to 8'h0F and `ALARM_SEL1` to 8'h81, so both banks hold a mix of alarm and event bits. With these values a bank-1 read is observed clearing alarm-driven pending flags, and the bank-0 alarm bits test the sticky-on-clear rule while the event bits beside them test plain clearing. The value of 2 for the synchronizer depth fixes alarm latency at three edges, and the reference model follows this delay with a history queue.

// File: rtl/stat_irq_pkg.sv
// Package: address map and widths shared by the status/interrupt block.
// Assumes: a 3-bit register address space; unmapped addresses read as 0.
package stat_irq_pkg;
    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] A_STAT0 = 3'd0;
    localparam logic [ADDR_W-1:0] A_STAT1 = 3'd1;
    localparam logic [ADDR_W-1:0] A_LIVE  = 3'd2;
    localparam logic [ADDR_W-1:0] A_MASK0 = 3'd4;
    localparam logic [ADDR_W-1:0] A_MASK1 = 3'd5;
endpackage

// File: rtl/alarm_sync.sv
// Module: alarm_sync
// Brings one asynchronous alarm level into the clock domain through DEPTH
// flops, and also provides the synchronized value from one cycle earlier so
// that the next stage can detect changes.
// Assumes: DEPTH >= 1; synchronous active-low reset drives everything to 0.
module alarm_sync #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q,
    output logic q_prev
);
    logic [DEPTH-1:0] chain;
    logic             last;

    // Shift the raw level along the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < DEPTH; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    // Keep the previous synchronized value for change detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last <= 1'b0;
        else        last <= chain[DEPTH-1];
    end

    assign q      = chain[DEPTH-1];
    assign q_prev = last;
endmodule

// File: rtl/stat_bit.sv
// Module: stat_bit
// One status position: a sticky status flag and a separate interrupt-pending
// flag. IS_ALARM picks the source type. An alarm is synchronized, sets status
// while present, and sets pending on each change. An event is a synchronous
// pulse that sets both flags.
// Assumes: event pulses are synchronous to clk; set wins over clear.
module stat_bit #(
    parameter bit IS_ALARM   = 1'b0,
    parameter int SYNC_DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src,
    input  logic clr,
    input  logic rd_hit,
    output logic stat_q,
    output logic pend_q
);
    logic set_now;
    logic trig;

    generate
        if (IS_ALARM) begin : g_alarm
            logic lvl, lvl_prev;
            alarm_sync #(.DEPTH(SYNC_DEPTH)) u_sync (
                .clk    (clk),
                .rst_n  (rst_n),
                .d      (src),
                .q      (lvl),
                .q_prev (lvl_prev)
            );
            assign set_now = lvl;
            assign trig    = lvl ^ lvl_prev;
        end else begin : g_event
            assign set_now = src;
            assign trig    = src;
        end
    endgenerate

    // Sticky status flag: cleared by host write, input set has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= 1'b0;
        else        stat_q <= (stat_q & ~clr) | set_now;
    end

    // Pending flag: dropped by a host read, re-armed by any trigger.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= (pend_q & ~rd_hit) | trig;
    end

    assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        set_now |=> stat_q);
    assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set_now) |=> !stat_q);
    assert_pend_trig_R3: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> pend_q);
    assert_read_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && !trig) |=> !pend_q);
endmodule

// File: rtl/stat_bank.sv
// Module: stat_bank
// One latched status register of W bits, its mask register and the bank's
// interrupt contribution. ALARM_SEL marks which bits are alarms.
// Assumes: clear vector, read hit and mask write come decoded from the top.
module stat_bank #(
    parameter int           W          = 8,
    parameter logic [W-1:0] ALARM_SEL  = '0,
    parameter int           SYNC_DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src,
    input  logic [W-1:0] clr_vec,
    input  logic         rd_hit,
    input  logic         mask_wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] stat,
    output logic [W-1:0] mask,
    output logic         irq
);
    logic [W-1:0] pend;

    generate
        for (genvar b = 0; b < W; b++) begin : g_bit
            stat_bit #(
                .IS_ALARM   (ALARM_SEL[b]),
                .SYNC_DEPTH (SYNC_DEPTH)
            ) u_bit (
                .clk    (clk),
                .rst_n  (rst_n),
                .src    (src[b]),
                .clr    (clr_vec[b]),
                .rd_hit (rd_hit),
                .stat_q (stat[b]),
                .pend_q (pend[b])
            );
        end
    endgenerate

    // Mask register: host-written enables, 1 lets the bit interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= '0;
        else if (mask_wr) mask <= wdata;
    end

    // Bank interrupt request from enabled pending bits.
    assign irq = |(pend & mask);

    assert_mask_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr |=> (mask == $past(wdata)));
    assert_mask_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_wr |=> $stable(mask));
endmodule

// File: rtl/stat_irq_ctrl.sv
// Module: stat_irq_ctrl (top)
// Host register port over two latched status banks, their masks and a live
// real-time register, plus the shared active-low interrupt line.
// Assumes: rd_en/wr_en are single-cycle strobes synchronous to clk; read
// data is registered and holds between reads.
module stat_irq_ctrl
    import stat_irq_pkg::*;
#(
    parameter int               REG_W      = 8,
    parameter logic [REG_W-1:0] ALARM_SEL0 = 8'h0F,
    parameter logic [REG_W-1:0] ALARM_SEL1 = 8'h00,
    parameter int               SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_W-1:0]  src0_in,
    input  logic [REG_W-1:0]  src1_in,
    input  logic [REG_W-1:0]  live_in,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data,
    output logic              irq_n
);
    logic [REG_W-1:0] stat0, stat1, mask0, mask1;
    logic [REG_W-1:0] clr0, clr1;
    logic             irq0, irq1;
    logic [REG_W-1:0] rd_mux;

    // Decode host writes to status addresses into per-bit clears.
    assign clr0 = (wr_en && addr == A_STAT0) ? wr_data : '0;
    assign clr1 = (wr_en && addr == A_STAT1) ? wr_data : '0;

    stat_bank #(.W(REG_W), .ALARM_SEL(ALARM_SEL0), .SYNC_DEPTH(SYNC_DEPTH)) u_bank0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .src     (src0_in),
        .clr_vec (clr0),
        .rd_hit  (rd_en && addr == A_STAT0),
        .mask_wr (wr_en && addr == A_MASK0),
        .wdata   (wr_data),
        .stat    (stat0),
        .mask    (mask0),
        .irq     (irq0)
    );

    stat_bank #(.W(REG_W), .ALARM_SEL(ALARM_SEL1), .SYNC_DEPTH(SYNC_DEPTH)) u_bank1 (
        .clk     (clk),
        .rst_n   (rst_n),
        .src     (src1_in),
        .clr_vec (clr1),
        .rd_hit  (rd_en && addr == A_STAT1),
        .mask_wr (wr_en && addr == A_MASK1),
        .wdata   (wr_data),
        .stat    (stat1),
        .mask    (mask1),
        .irq     (irq1)
    );

    // Select the register addressed by the host.
    always_comb begin
        case (addr)
            A_STAT0: rd_mux = stat0;
            A_STAT1: rd_mux = stat1;
            A_LIVE:  rd_mux = live_in;
            A_MASK0: rd_mux = mask0;
            A_MASK1: rd_mux = mask1;
            default: rd_mux = '0;
        endcase
    end

    // Registered read data, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_mux;
    end

    assign irq_n = ~(irq0 | irq1);

    assert_live_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == A_LIVE) |=> (rd_data == $past(live_in)));
    assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
    assert_unmapped_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (addr == 3'd3 || addr > A_MASK1)) |=> (rd_data == '0));
    assert_irq_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mask0 == '0 && mask1 == '0) |-> irq_n);
endmodule

// File: tb/tb_stat_irq_ctrl.sv
// Bench: behavioural reference model, compared with the outputs every cycle.
module tb_stat_irq_ctrl;
    localparam logic [7:0] SEL0 = 8'h0F;
    localparam logic [7:0] SEL1 = 8'h81;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] src0_in = '0, src1_in = '0, live_in = '0, wr_data = '0;
    logic [2:0] addr = '0;
    logic       rd_en = 1'b0, wr_en = 1'b0;
    logic [7:0] rd_data;
    logic       irq_n;

    int vectors = 0;
    int errors  = 0;
    bit chk_on  = 1'b0;
    string tag  = "R1";

    always #5 clk = ~clk;

    stat_irq_ctrl #(.REG_W(8), .ALARM_SEL0(SEL0), .ALARM_SEL1(SEL1), .SYNC_DEPTH(2)) dut (
        .clk(clk), .rst_n(rst_n), .src0_in(src0_in), .src1_in(src1_in),
        .live_in(live_in), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .irq_n(irq_n)
    );

    // Reference model state.
    logic [7:0] m_stat [2];
    logic [7:0] m_pend [2];
    logic [7:0] m_mask [2];
    logic [7:0] m_rd;
    logic       m_irq_n;
    logic [7:0] hist0 [$];
    logic [7:0] hist1 [$];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < 2; r++) begin
                m_stat[r] = '0; m_pend[r] = '0; m_mask[r] = '0;
            end
            m_rd = '0;
            hist0 = '{8'h0, 8'h0, 8'h0, 8'h0};
            hist1 = '{8'h0, 8'h0, 8'h0, 8'h0};
        end else begin
            logic [7:0] lvl, chg, ev, srcv, sel;
            hist0.push_front(src0_in); void'(hist0.pop_back());
            hist1.push_front(src1_in); void'(hist1.pop_back());
            if (rd_en) begin
                case (addr)
                    3'd0: m_rd = m_stat[0];
                    3'd1: m_rd = m_stat[1];
                    3'd2: m_rd = live_in;
                    3'd4: m_rd = m_mask[0];
                    3'd5: m_rd = m_mask[1];
                    default: m_rd = '0;
                endcase
            end
            for (int r = 0; r < 2; r++) begin
                sel  = (r == 0) ? SEL0 : SEL1;
                srcv = (r == 0) ? src0_in : src1_in;
                lvl  = ((r == 0) ? hist0[2] : hist1[2]) & sel;
                chg  = ((r == 0) ? (hist0[2] ^ hist0[3]) : (hist1[2] ^ hist1[3])) & sel;
                ev   = srcv & ~sel;
                if (wr_en && addr == r) m_stat[r] = m_stat[r] & ~wr_data;
                m_stat[r] = m_stat[r] | lvl | ev;
                if (rd_en && addr == r) m_pend[r] = '0;
                m_pend[r] = m_pend[r] | chg | ev;
                if (wr_en && addr == 3'(4 + r)) m_mask[r] = wr_data;
            end
        end
        m_irq_n = ~|((m_pend[0] & m_mask[0]) | (m_pend[1] & m_mask[1]));
    end

    // Compare outputs away from the active edge.
    always @(negedge clk) begin
        if (chk_on) begin
            vectors++;
            if (irq_n !== m_irq_n) begin
                errors++;
                $display("FAIL %s/R7 irq_n actual=%b expected=%b", tag, irq_n, m_irq_n);
            end
            vectors++;
            if (rd_data !== m_rd) begin
                errors++;
                $display("FAIL %s/R10 rd_data actual=%h expected=%h", tag, rd_data, m_rd);
            end
        end
    end

    task automatic step(input logic [7:0] s0, input logic [7:0] s1,
                        input logic r, input logic w, input logic [2:0] a,
                        input logic [7:0] d);
        @(posedge clk); #1;
        src0_in = s0; src1_in = s1; rd_en = r; wr_en = w; addr = a; wr_data = d;
    endtask

    task automatic idle(input int n, input logic [7:0] s0, input logic [7:0] s1);
        for (int i = 0; i < n; i++) step(s0, s1, 1'b0, 1'b0, 3'd0, 8'h0);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset values at the ports
        vectors++;
        if (irq_n !== 1'b1 || rd_data !== 8'h00) begin
            errors++;
            $display("FAIL R1 reset actual=%b/%h expected=1/00", irq_n, rd_data);
        end
        chk_on = 1'b1;

        tag = "R9";
        step(0, 0, 1'b0, 1'b1, 3'd4, 8'hFF);
        step(0, 0, 1'b0, 1'b1, 3'd5, 8'hFF);
        step(0, 0, 1'b1, 1'b0, 3'd4, 8'h0);
        step(0, 0, 1'b1, 1'b0, 3'd5, 8'h0);

        tag = "R2";
        step(8'h20, 8'h02, 1'b0, 1'b0, 3'd0, 8'h0);
        idle(3, 0, 0);
        step(0, 0, 1'b1, 1'b0, 3'd0, 8'h0);
        step(0, 0, 1'b1, 1'b0, 3'd1, 8'h0);

        tag = "R3";
        idle(6, 8'h01, 8'h80);
        step(8'h01, 8'h80, 1'b1, 1'b0, 3'd0, 8'h0);
        step(8'h01, 8'h80, 1'b1, 1'b0, 3'd1, 8'h0);
        idle(6, 8'h00, 8'h00);
        step(0, 0, 1'b1, 1'b0, 3'd1, 8'h0);

        tag = "R4";
        step(8'h01, 0, 1'b0, 1'b1, 3'd0, 8'h21);
        idle(5, 8'h01, 0);
        step(8'h01, 0, 1'b0, 1'b1, 3'd0, 8'h01);
        step(8'h01, 0, 1'b1, 1'b0, 3'd0, 8'h0);
        step(0, 0, 1'b0, 1'b1, 3'd1, 8'hFF);
        step(0, 0, 1'b1, 1'b0, 3'd1, 8'h0);

        tag = "R5";
        step(8'h40, 0, 1'b0, 1'b1, 3'd0, 8'h40);
        step(0, 0, 1'b1, 1'b0, 3'd0, 8'h0);

        tag = "R6";
        step(8'h10, 0, 1'b1, 1'b0, 3'd0, 8'h0);
        idle(2, 0, 0);
        step(0, 0, 1'b1, 1'b0, 3'd0, 8'h0);

        tag = "R8";
        for (int i = 0; i < 20; i++) begin
            live_in = 8'($urandom);
            step(0, 0, 1'b1, i[0], 3'd2, 8'($urandom));
        end

        tag = "R10";
        step(0, 0, 1'b1, 1'b0, 3'd3, 8'h0);
        step(0, 0, 1'b1, 1'b0, 3'd6, 8'h0);
        step(0, 0, 1'b1, 1'b0, 3'd7, 8'h0);
        idle(3, 0, 0);

        tag = "R7";
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] s0, s1;
            s0 = (SEL0 & ((($urandom % 16) == 0) ? 8'($urandom) : src0_in))
               | (~SEL0 & (($urandom % 4 == 0) ? 8'($urandom) : 8'h0));
            s1 = (SEL1 & ((($urandom % 16) == 0) ? 8'($urandom) : src1_in))
               | (~SEL1 & (($urandom % 4 == 0) ? 8'($urandom) : 8'h0));
            live_in = 8'($urandom);
            step(s0, s1, ($urandom % 3 == 0), ($urandom % 5 == 0),
                 3'($urandom), 8'($urandom));
        end
        idle(4, 0, 0);
        finish_run();
    end
endmodule